// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides, for a single twisted-pair port of a repeater, whether the far end is present. It watches two kinds of receive activity: a strobe for each packet that starts arriving and a strobe for each decoded link test pulse. From these it keeps the port in either a link-good or a link-fail state. A port that hears nothing for too long is declared failed. It comes back when one packet arrives, or when an unbroken run of link pulses arrives with each pulse inside the receive-idle window.

While the port is failed, the block blocks all transmission toward it, and it raises a one-cycle drop strobe for the packet that ends the failure, so that the repeater core discards it. While the port is good, the block watches the port's own transmitter and requests an idle link pulse whenever the transmitter has been quiet for longer than the idle limit. A management enable turns monitoring off, which holds the port in link good. All intervals are counted in ticks of an external one-millisecond strobe, and the limits are parameters.

Top module: `tp_link_monitor`

## Requirements
- R1: In link good, when the (FAIL_MS+1)-th `ms_tick` arrives with no receive activity since the last activity, the port enters link fail: `link_ok` goes 0 and `tx_block` goes 1 in the cycle after that tick.
- R2: Any receive activity (`rx_pkt` or `rx_lp` high for a cycle) restarts the receive-idle count from zero, so FAIL_MS ticks after activity never cause a failure.
- R3: In link fail, LINK_PULSES link pulses, each within the receive-idle window, return the port to link good (`link_ok`=1, `tx_block`=0) in the cycle after the last pulse. Fewer pulses leave it failed.
- R4: A link pulse that arrives after the receive-idle window has expired (more than FAIL_MS ticks since the previous activity) restarts the consecutive pulse count at one.
- R5: A packet strobe in link fail returns the port to link good and raises `drop_pkt` for exactly the following cycle. A packet in link good never raises `drop_pkt`.
- R6: `tx_block` is 1 exactly while the port is in link fail, and `lp_req` stays 0 for the whole time the port is failed.
- R7: In link good, `lp_req` pulses for one cycle in the cycle after the (IDLE_MS+1)-th tick with `tx_busy` low. Both `tx_busy` and the request itself restart the idle count.
- R8: With `lt_en` low, the port is in link good from the next cycle on and never times out. After `lt_en` returns high, the receive-idle count starts again from zero.
- R9: Under reset and directly after it, the port is in link fail with the pulse count cleared: `link_ok`=0, `tx_block`=1, `lp_req`=0, `drop_pkt`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| rx_pkt | input | 1 | One-cycle strobe at the start of a received packet |
| rx_lp | input | 1 | One-cycle strobe for each decoded link test pulse |
| tx_busy | input | 1 | Port transmitter is sending |
| lt_en | input | 1 | Link monitoring enable; low forces link good |
| link_ok | output | 1 | Link good status |
| tx_block | output | 1 | Inhibit all transmission toward the port |
| drop_pkt | output | 1 | One-cycle strobe: discard the packet just received |
| lp_req | output | 1 | One-cycle request to send an idle link pulse |

## Verification
The main function is driven with several patterns. A pulse run that stops one short of the required length separates a correct count threshold from an off-by-one. A run split by a long silence, whose total would otherwise be enough, shows that stale pulses restart the count. A timeout approached tick by tick, with and without a refreshing pulse just before the limit, pins the exact tick on which the port fails. The transmit side is tried with an uninterrupted idle stretch and with a stretch interrupted by a busy cycle, which shows whether the idle count restarts. A sequence with the enable removed and then restored shows that forcing link good also restarts the receive timer.

// File: rtl/tplm_pkg.sv
package tplm_pkg;
  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_GOOD = 1'b1
  } link_st_e;
endpackage

// File: rtl/tplm_idle_timer.sv
// Counts ms ticks since the last clear. fire flags the tick that pushes the
// count past LIMIT. WRAP=0 saturates one above LIMIT (stale stays high);
// WRAP=1 restarts at zero after firing.
module tplm_idle_timer #(
  parameter int LIMIT = 60,
  parameter bit WRAP  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic fire,
  output logic stale
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] PAST = CW'(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign fire  = tick && !clr && (cnt == TOP);
  assign stale = (cnt == PAST);

  generate
    if (WRAP) begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst || clr)
          cnt <= '0;
        else if (tick)
          cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
      end

      assert_idle_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);
    end else begin : g_sat
      always_ff @(posedge clk) begin
        if (rst || clr)
          cnt <= '0;
        else if (tick && cnt != PAST)
          cnt <= cnt + 1'b1;
      end

      assert_rx_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= PAST);
    end
  endgenerate
endmodule

// File: rtl/tplm_pulse_run.sv
// Counts consecutive link pulses; restart makes the current pulse the first.
module tplm_pulse_run #(
  parameter int N = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pulse,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] NV = CW'(N);

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;

  assign nxt  = restart ? CW'(1) : cnt + 1'b1;
  assign done = pulse && (nxt == NV);

  always_ff @(posedge clk) begin
    if (rst || clr || done)
      cnt <= '0;
    else if (pulse)
      cnt <= nxt;
  end

  assert_run_below_target_R3: assert property (@(posedge clk) disable iff (rst)
    cnt < NV);
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import tplm_pkg::*;
#(
  parameter int FAIL_MS     = 60,
  parameter int IDLE_MS     = 16,
  parameter int LINK_PULSES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic rx_pkt,
  input  logic rx_lp,
  input  logic tx_busy,
  input  logic lt_en,
  output logic link_ok,
  output logic tx_block,
  output logic drop_pkt,
  output logic lp_req
);
  link_st_e st, st_nxt;
  logic rx_act;
  logic rx_fire, rx_stale;
  logic tx_fire, tx_unused_stale;
  logic run_done;

  assign rx_act = rx_pkt || rx_lp;

  // Receive-idle window; saturates so that a stale window is remembered.
  tplm_idle_timer #(.LIMIT(FAIL_MS), .WRAP(1'b0)) u_rx_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .clr  (rx_act || !lt_en),
    .fire (rx_fire),
    .stale(rx_stale)
  );

  // Transmit-idle window; only runs while the link is good.
  tplm_idle_timer #(.LIMIT(IDLE_MS), .WRAP(1'b1)) u_tx_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .clr  (tx_busy || st != LNK_GOOD),
    .fire (tx_fire),
    .stale(tx_unused_stale)
  );

  tplm_pulse_run #(.N(LINK_PULSES)) u_run (
    .clk    (clk),
    .rst    (rst),
    .clr    (st == LNK_GOOD || !lt_en),
    .pulse  (rx_lp),
    .restart(rx_stale),
    .done   (run_done)
  );

  always_comb begin
    st_nxt = st;
    if (!lt_en)
      st_nxt = LNK_GOOD;
    else if (st == LNK_GOOD) begin
      if (rx_fire) st_nxt = LNK_FAIL;
    end else begin
      if (rx_pkt || run_done) st_nxt = LNK_GOOD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= LNK_FAIL;
      link_ok  <= 1'b0;
      tx_block <= 1'b1;
      drop_pkt <= 1'b0;
      lp_req   <= 1'b0;
    end else begin
      st       <= st_nxt;
      link_ok  <= (st_nxt == LNK_GOOD);
      tx_block <= (st_nxt == LNK_FAIL);
      drop_pkt <= lt_en && rx_pkt && (st == LNK_FAIL);
      lp_req   <= tx_fire && (st_nxt == LNK_GOOD);
    end
  end

  assert_fail_no_lp_R6: assert property (@(posedge clk) disable iff (rst)
    tx_block |-> !lp_req);

  assert_disable_forces_good_R8: assert property (@(posedge clk) disable iff (rst)
    !lt_en |=> link_ok);

  assert_drop_only_on_recovery_R5: assert property (@(posedge clk) disable iff (rst)
    drop_pkt |-> (link_ok && $past(tx_block)));

  assert_lp_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    lp_req |=> !lp_req);
endmodule

// File: tb/tp_link_monitor_test.sv
`timescale 1ns/1ps
module tp_link_monitor_test;
  localparam int FAIL_MS = 6;
  localparam int IDLE_MS = 3;
  localparam int NPULSE  = 6;

  logic clk = 1'b0;
  logic rst, ms_tick, rx_pkt, rx_lp, tx_busy, lt_en;
  logic link_ok, tx_block, drop_pkt, lp_req;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tp_link_monitor #(.FAIL_MS(FAIL_MS), .IDLE_MS(IDLE_MS), .LINK_PULSES(NPULSE)) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .rx_pkt(rx_pkt), .rx_lp(rx_lp),
    .tx_busy(tx_busy), .lt_en(lt_en), .link_ok(link_ok), .tx_block(tx_block),
    .drop_pkt(drop_pkt), .lp_req(lp_req)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rx_lp = 1'b1;
      @(negedge clk) rx_lp = 1'b0;
    end
  endtask

  task automatic packet();
    @(negedge clk) rx_pkt = 1'b1;
    @(negedge clk) rx_pkt = 1'b0;
  endtask

  task automatic test_reset_R9();
    chk("R9", "link_ok", link_ok, 1'b0);
    chk("R9", "tx_block", tx_block, 1'b1);
    chk("R9", "lp_req", lp_req, 1'b0);
    chk("R9", "drop_pkt", drop_pkt, 1'b0);
  endtask

  task automatic test_pulse_recovery_R3();
    pulses(NPULSE - 1);
    chk("R3", "link_ok short run", link_ok, 1'b0);
    pulses(1);
    chk("R3", "link_ok full run", link_ok, 1'b1);
    chk("R3", "tx_block full run", tx_block, 1'b0);
  endtask

  task automatic test_lp_request_R7();
    bit seen;
    ticks(IDLE_MS);
    chk("R7", "lp_req before limit", lp_req, 1'b0);
    ticks(1);
    chk("R7", "lp_req at limit", lp_req, 1'b1);
    step();
    chk("R7", "lp_req one cycle", lp_req, 1'b0);
    pulses(1);
    ticks(2);
    @(negedge clk) tx_busy = 1'b1;
    @(negedge clk) tx_busy = 1'b0;
    seen = 0;
    for (int i = 0; i < IDLE_MS; i++) begin
      ticks(1);
      if (lp_req) seen = 1;
    end
    chk("R7", "lp_req after busy restart", seen, 1'b0);
    ticks(1);
    chk("R7", "lp_req after busy full idle", lp_req, 1'b1);
  endtask

  task automatic test_activity_restart_R2();
    pulses(1);
    ticks(FAIL_MS - 1);
    pulses(1);
    ticks(FAIL_MS - 1);
    chk("R2", "link_ok after refresh", link_ok, 1'b1);
  endtask

  task automatic test_timeout_R1();
    ticks(1);
    chk("R1", "link_ok at limit", link_ok, 1'b1);
    ticks(1);
    chk("R1", "link_ok past limit", link_ok, 1'b0);
    chk("R1", "tx_block past limit", tx_block, 1'b1);
  endtask

  task automatic test_fail_silent_R6();
    bit seen = 0;
    for (int i = 0; i < 2 * FAIL_MS; i++) begin
      ticks(1);
      if (lp_req) seen = 1;
    end
    chk("R6", "lp_req while failed", seen, 1'b0);
    chk("R6", "tx_block while failed", tx_block, 1'b1);
  endtask

  task automatic test_stale_pulse_R4();
    pulses(3);
    chk("R4", "link_ok after three", link_ok, 1'b0);
    ticks(FAIL_MS + 1);
    pulses(NPULSE - 1);
    chk("R4", "link_ok split run", link_ok, 1'b0);
    pulses(1);
    chk("R4", "link_ok restarted run", link_ok, 1'b1);
  endtask

  task automatic test_packet_recovery_R5();
    ticks(FAIL_MS + 1);
    chk("R5", "link_ok before packet", link_ok, 1'b0);
    packet();
    chk("R5", "link_ok after packet", link_ok, 1'b1);
    chk("R5", "drop_pkt recovery packet", drop_pkt, 1'b1);
    step();
    chk("R5", "drop_pkt one cycle", drop_pkt, 1'b0);
    packet();
    chk("R5", "drop_pkt packet in good", drop_pkt, 1'b0);
  endtask

  task automatic test_disable_R8();
    ticks(FAIL_MS + 1);
    chk("R8", "link_ok failed before disable", link_ok, 1'b0);
    @(negedge clk) lt_en = 1'b0;
    step();
    chk("R8", "link_ok forced", link_ok, 1'b1);
    chk("R8", "tx_block forced", tx_block, 1'b0);
    ticks(2 * FAIL_MS);
    chk("R8", "link_ok no timeout", link_ok, 1'b1);
    @(negedge clk) lt_en = 1'b1;
    step();
    ticks(FAIL_MS);
    chk("R8", "link_ok restarted window", link_ok, 1'b1);
    ticks(1);
    chk("R8", "link_ok timeout after enable", link_ok, 1'b0);
  endtask

  initial begin
    rst = 1'b1; ms_tick = 1'b0; rx_pkt = 1'b0; rx_lp = 1'b0;
    tx_busy = 1'b0; lt_en = 1'b1;
    repeat (3) step();
    test_reset_R9();
    rst = 1'b0;
    step();
    test_reset_R9();
    test_pulse_recovery_R3();
    test_lp_request_R7();
    test_activity_restart_R2();
    test_timeout_R1();
    test_fail_silent_R6();
    test_stale_pulse_R4();
    test_packet_recovery_R5();
    test_disable_R8();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule